// File: doc/BRIEF.md
# Digital Threshold Trigger Detector

This block watches a stream of signed 14-bit converter samples and raises a trigger when the stream meets one of five selectable threshold conditions. It compares each valid sample with a programmable low and a programmable high threshold. Three conditions depend only on the current sample: above the high threshold, below the low threshold, or inside the window between them. Two hysteresis conditions also use the opposite threshold. After they fire, they must see a crossing of that threshold before they can fire again, so noise around one threshold cannot produce a burst of triggers.

A two-state machine drives the outputs. In state ARMED the detector may fire. In state FIRED it has fired and waits for its re-arm condition. The transition ARMED->FIRED (named FIRE) happens on a valid sample that meets the fire condition and emits a one-clock pulse. The transition FIRED->ARMED (named REARM) happens on a valid sample that meets the re-arm condition. The transition RESELECT forces ARMED from either state whenever the condition select changes. The level output shows that the machine is in FIRED.

Top module: `threshold_trigger`

## Requirements
- R1: While reset is low and on the first cycle after it, `trig_pulse` and `trig_level` are 0 and the detector is armed.
- R2: Samples and thresholds are 14-bit two's complement, so -8192 (0x2000) is the smallest value and 8191 (0x1FFF) is the largest, and all comparisons are signed.
- R3: With `cond_sel` = 0 (above-high), the detector fires when the sample is strictly greater than `thr_hi`, and it re-arms on a valid sample that is not.
- R4: With `cond_sel` = 1 (below-low), the detector fires when the sample is strictly less than `thr_lo`, and it re-arms on a valid sample that is not.
- R5: With `cond_sel` = 2 (inside-window), the detector fires when `thr_lo` <= sample <= `thr_hi`, and it re-arms on a valid sample outside that range.
- R6: With `cond_sel` = 3 (high-hysteresis), the detector fires when the sample is greater than `thr_hi`. After firing it can fire again only after a valid sample less than `thr_lo` has re-armed it.
- R7: With `cond_sel` = 4 (low-hysteresis), the detector fires when the sample is less than `thr_lo`. After firing it can fire again only after a valid sample greater than `thr_hi` has re-armed it.
- R8: Samples are evaluated only in cycles where `smp_valid` is 1. In other cycles `trig_pulse` is 0 and `trig_level` holds its value.
- R9: A firing sample, taken at clock edge k, drives `trig_pulse` high for exactly the one clock after edge k. From the same edge, `trig_level` stays 1 until the REARM transition.
- R10: In a cycle where `cond_sel` differs from its value in the previous cycle, the detector returns to armed, ignores the sample and does not pulse. Codes 5 to 7 never fire and keep `trig_level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed sample |
| thr_lo | input | 14 | Signed low threshold |
| thr_hi | input | 14 | Signed high threshold |
| cond_sel | input | 3 | Trigger condition code (0 to 4 used) |
| trig_pulse | output | 1 | One-clock trigger pulse |
| trig_level | output | 1 | High while in FIRED |

## Verification
Both outputs are registered once. A sample driven before edge k therefore shows its pulse and level in the cycle after edge k, and the next edge clears the pulse again. The bench drives every input on the falling edge and lets one rising edge pass. It compares both outputs on the following falling edge against a model that advances in the same step. That model covers every valid sample, idle gap and select change. Each ramp sweeps the full signed range in both directions, and the values at and beside each threshold are added, so every fire and re-arm boundary falls on a checked cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int SMP_W = 14;

    typedef enum logic [2:0] {
        COND_ABOVE   = 3'd0,
        COND_BELOW   = 3'd1,
        COND_INSIDE  = 3'd2,
        COND_HYST_HI = 3'd3,
        COND_HYST_LO = 3'd4
    } cond_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_FIRED = 1'b1
    } trig_state_e;

    typedef struct packed {
        logic above_hi;
        logic below_lo;
        logic in_window;
    } cmp_flags_t;

endpackage

// File: rtl/thr_compare.sv
module thr_compare #(
    parameter int W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic signed [W-1:0] sample,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output trig_pkg::cmp_flags_t flags
);

    always_comb begin
        flags.above_hi  = sample > hi;
        flags.below_lo  = sample < lo;
        flags.in_window = (sample >= lo) && (sample <= hi);
    end

    // R2: with ordered thresholds a sample lies on exactly one side or inside
    p_one_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lo <= hi) |-> $countones({flags.above_hi, flags.below_lo, flags.in_window}) == 1);

endmodule

// File: rtl/trig_cond_sel.sv
module trig_cond_sel (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cond,
    input  trig_pkg::cmp_flags_t flags,
    output logic                 fire_hit,
    output logic                 rearm_hit
);
    import trig_pkg::*;

    always_comb begin
        unique case (cond)
            COND_ABOVE: begin
                fire_hit  = flags.above_hi;
                rearm_hit = !flags.above_hi;
            end
            COND_BELOW: begin
                fire_hit  = flags.below_lo;
                rearm_hit = !flags.below_lo;
            end
            COND_INSIDE: begin
                fire_hit  = flags.in_window;
                rearm_hit = !flags.in_window;
            end
            COND_HYST_HI: begin
                fire_hit  = flags.above_hi;
                rearm_hit = flags.below_lo;
            end
            COND_HYST_LO: begin
                fire_hit  = flags.below_lo;
                rearm_hit = flags.above_hi;
            end
            default: begin
                fire_hit  = 1'b0;
                rearm_hit = 1'b1;
            end
        endcase
    end

    // R10: codes above the defined set never request a firing
    p_undef_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cond > 3'd4) |-> !fire_hit);

endmodule

// File: rtl/threshold_trigger.sv
module threshold_trigger #(
    parameter int SMP_W = trig_pkg::SMP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic signed [SMP_W-1:0] thr_lo,
    input  logic signed [SMP_W-1:0] thr_hi,
    input  logic [2:0]             cond_sel,
    output logic                   trig_pulse,
    output logic                   trig_level
);
    import trig_pkg::*;

    cmp_flags_t  flags;
    logic        fire_hit;
    logic        rearm_hit;
    logic [2:0]  cond_q;
    logic        cond_chg;
    logic        fire_now;
    trig_state_e state_q;
    trig_state_e state_d;

    thr_compare #(.W(SMP_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (smp_data),
        .lo     (thr_lo),
        .hi     (thr_hi),
        .flags  (flags)
    );

    trig_cond_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (cond_sel),
        .flags     (flags),
        .fire_hit  (fire_hit),
        .rearm_hit (rearm_hit)
    );

    assign cond_chg = (cond_sel != cond_q);

    // Transitions: FIRE, REARM, RESELECT
    always_comb begin
        state_d  = state_q;
        fire_now = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (!cond_chg && smp_valid && fire_hit) begin
                    state_d  = ST_FIRED;
                    fire_now = 1'b1;
                end
            end
            ST_FIRED: begin
                if (cond_chg)
                    state_d = ST_ARMED;
                else if (smp_valid && rearm_hit)
                    state_d = ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            cond_q  <= 3'd0;
        end else begin
            state_q <= state_d;
            cond_q  <= cond_sel;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_pulse <= 1'b0;
            trig_level <= 1'b0;
        end else begin
            trig_pulse <= fire_now;
            trig_level <= (state_d == ST_FIRED);
        end
    end

    // R8: a pulse only follows a valid sample
    p_pulse_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(smp_valid));

    // R8: idle cycles with an unchanged select leave the level alone
    p_idle_holds_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !cond_chg) |=> $stable(trig_level));

    // R9: pulse lasts a single clock
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R9: a pulse always comes with the level raised
    p_pulse_with_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> trig_level);

    // R10: a select change suppresses the pulse and drops the level
    p_reselect_arms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cond_chg |=> (!trig_pulse && !trig_level));

endmodule

// File: tb/threshold_trigger_test.sv
module threshold_trigger_test;

    localparam int W = 14;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                smp_valid = 1'b0;
    logic signed [W-1:0] smp_data = '0;
    logic signed [W-1:0] thr_lo = '0;
    logic signed [W-1:0] thr_hi = '0;
    logic [2:0]          cond_sel = 3'd0;
    logic                trig_pulse;
    logic                trig_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    bit m_fired = 0;
    bit m_pulse = 0;
    int m_cond_prev = 0;

    always #2 clk = ~clk;

    threshold_trigger uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .thr_lo     (thr_lo),
        .thr_hi     (thr_hi),
        .cond_sel   (cond_sel),
        .trig_pulse (trig_pulse),
        .trig_level (trig_level)
    );

    function automatic string tag_of(int c);
        case (c)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, bit exp_p, bit exp_l);
        checks++;
        if (trig_pulse !== exp_p || trig_level !== exp_l) begin
            fails++;
            $display("FAIL %s: pulse=%0b level=%0b expected pulse=%0b level=%0b (cond %0d sample %0d)",
                     tag, trig_pulse, trig_level, exp_p, exp_l, cond_sel, smp_data);
        end
    endtask

    // one clock: drive, advance model at the edge, compare at the falling edge
    task automatic step(bit v, int s, string tag);
        int lo, hi, c;
        bit f, r;
        smp_valid = v;
        smp_data  = W'(s);
        lo = int'(thr_lo);
        hi = int'(thr_hi);
        c  = int'(cond_sel);
        case (c)
            0: begin f = s > hi; r = !f; end
            1: begin f = s < lo; r = !f; end
            2: begin f = (s >= lo) && (s <= hi); r = !f; end
            3: begin f = s > hi; r = s < lo; end
            4: begin f = s < lo; r = s > hi; end
            default: begin f = 0; r = 1; end
        endcase
        @(posedge clk);
        m_pulse = 0;
        if (c != m_cond_prev) begin
            m_fired = 0;                       // R10 reselect
        end else if (v) begin
            if (!m_fired && f) begin m_fired = 1; m_pulse = 1; end
            else if (m_fired && r) m_fired = 0;
        end
        m_cond_prev = c;
        @(negedge clk);
        check(v ? tag : "R8", m_pulse, m_fired);
    endtask

    task automatic boundaries(string tag);
        int lo, hi;
        lo = int'(thr_lo);
        hi = int'(thr_hi);
        for (int k = -1; k <= 1; k++) begin
            if (hi + k <= 8191 && hi + k >= -8192) step(1, hi + k, tag);
            if (lo + k <= 8191 && lo + k >= -8192) step(1, lo + k, tag);
        end
        for (int k = 1; k >= -1; k--) begin
            if (lo + k <= 8191 && lo + k >= -8192) step(1, lo + k, tag);
            if (hi + k <= 8191 && hi + k >= -8192) step(1, hi + k, tag);
        end
    endtask

    task automatic sweep(int c, int lo, int hi);
        string tag;
        int n;
        smp_valid = 0;
        thr_lo    = W'(lo);
        thr_hi    = W'(hi);
        cond_sel  = 3'(c);
        tag       = tag_of(c);
        step(0, 0, "R10");                     // reselect cycle
        n = 0;
        for (int rep = 0; rep < 2; rep++) begin
            for (int s = -8192; s <= 8191; s += 61) begin
                n++;
                if (n % 7 == 0) step(0, (n % 2) ? 8191 : -8192, "R8");
                step(1, s, tag);
            end
            boundaries(tag);
            for (int s = 8191; s >= -8192; s -= 61) begin
                n++;
                if (n % 7 == 0) step(0, (n % 2) ? 8191 : -8192, "R8");
                step(1, s, tag);
            end
            boundaries(tag);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1", 0, 0);                     // R1 during reset
        rst_n = 1;
        @(negedge clk);
        check("R1", 0, 0);                     // R1 first cycle out of reset
        // R2: signed thresholds on both sides of zero, then the extremes
        for (int c = 0; c <= 5; c++) sweep(c, -100, 200);
        for (int c = 0; c <= 4; c++) sweep(c, -8192, 8191);
        for (int c = 0; c <= 4; c++) sweep(c, 1000, 1000);
        sweep(7, 0, 0);                        // R10 undefined code
        // R9: hold above high in high-hysteresis, single pulse then level held
        cond_sel = 3'd3; thr_lo = -10; thr_hi = 10;
        step(0, 0, "R10");
        step(1, 50, "R9");
        step(1, 60, "R9");
        step(1, 0, "R6");
        step(1, 60, "R6");
        step(1, -20, "R6");
        step(1, 60, "R9");
        // R10: change select while fired
        cond_sel = 3'd0;
        step(1, 60, "R10");
        step(1, 60, "R3");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule